// File: doc/BRIEF.md
# Parallel FPGA Configuration Loader

This block is the master side of a byte-wide slave parallel configuration port. On a start pulse it pulses the target's active-low program line and waits for the target's active-low init line to fall and then to rise again. It then selects the port for writing and waits out a settling delay. After that it takes bitstream bytes from a valid/ready stream and clocks each one into the target with one low-then-high pulse on the configuration clock.

Before each byte the loader samples the done and init lines. If done is already high, it stops sending bytes. If init is low, the target has reported a configuration (CRC) error. Once the last byte has gone out, the loader releases the chip select, then the write strobe, and waits for done high together with init high. Each waiting phase has its own timeout, counted in system clock cycles. The loader ends every run with a one-cycle success or failure pulse. A failure also carries a 3-bit code naming the phase that failed.

The three target status inputs each pass through a two-flop synchroniser. `HALF_CCLK` sets the length of each configuration clock half period in system clocks, and it must be at least 2. `CHECK_BUSY` selects whether the loader waits on the busy line after each clock edge.

Top module: `fpga_cfg_loader`

## Requirements
- R1: After reset, `prog_n`, `cs_n`, `wr_n` and `cclk` are high, and `s_ready`, `cfg_ok` and `cfg_fail` are low. A `start` pulse is acted on only while the loader is idle. A start during a run does not restart the program pulse and does not change the bytes delivered.
- R2: On start, `prog_n` goes low for at least `PROG_PULSE` cycles. It stays low until the synchronised `init_n` is seen low. If `init_n` is not seen low within `INIT_TO` cycles after the pulse, the run fails with code 1.
- R3: After `init_n` is seen low, `prog_n` is released. The loader then waits for `init_n` high, and fails with code 2 if it is not seen within `INIT_TO` cycles.
- R4: Once `init_n` is high, `cs_n` and `wr_n` go low together. `s_ready` does not rise until at least `SETTLE` cycles later.
- R5: `s_ready` is high only while the port is selected and a byte is awaited. Each accepted byte is driven on `cfg_d` before `cclk` falls. `cclk` then stays low for exactly `HALF_CCLK` cycles and rises with `cfg_d` unchanged, so there is one rising edge per byte.
- R6: If the synchronised `init_n` is low when the loader checks before a byte, no further byte is sent and the run fails with code 3.
- R7: With `CHECK_BUSY` set, the next byte is held off while `busy_in` is high after a rising edge. If busy stays high for `BUSY_TO` cycles, the run fails with code 4.
- R8: If `done_in` is high when the loader checks before a byte, it accepts no further byte and goes to the final check.
- R9: When the bytes are finished, `cs_n` rises one cycle before `wr_n`. The loader then pulses `cfg_ok` once `done_in` and `init_n` are both high. If they are not both high within `CFG_TO` cycles, the run fails with code 5.
- R10: Every failure gives a one-cycle `cfg_fail` pulse with `prog_n`, `cs_n` and `wr_n` high. `fail_code` holds a value from 1 to 5 until the next failure. `cfg_ok` and `cfg_fail` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a configuration run (acted on when idle) |
| s_data | input | DATA_W | Bitstream byte |
| s_valid | input | 1 | Byte on `s_data` is valid |
| s_last | input | 1 | Byte on `s_data` is the final one |
| s_ready | output | 1 | Loader accepts a byte this cycle |
| prog_n | output | 1 | Target program request, active low |
| cclk | output | 1 | Configuration clock to target |
| cs_n | output | 1 | Target chip select, active low |
| wr_n | output | 1 | Target write strobe, active low |
| cfg_d | output | DATA_W | Configuration data bus |
| init_n | input | 1 | Target init/error line, active low |
| done_in | input | 1 | Target configuration done |
| busy_in | input | 1 | Target busy |
| cfg_ok | output | 1 | One-cycle pulse: configuration succeeded |
| cfg_fail | output | 1 | One-cycle pulse: configuration failed |
| fail_code | output | 3 | Phase code of the last failure (1 to 5) |

## Verification
The assertions check on every cycle the properties that hold in every state:
- `s_ready` appears only with the port selected.
- The port is never selected while `prog_n` is low.
- `cfg_d` is stable at each rising `cclk`.
- `cclk` is low only while the port is selected.
- The chip select is released before the write strobe.
- A failure pulse carries a valid code and leaves every control line released.

Only the bench scenarios can show the sequencing against a modelled target. These cover the timeout code of each phase and the byte count at which an early done or an init error stops the stream. They also cover the settle gap before the first byte, the exact clock low width, and that a start during a run is ignored.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PROG,
      ST_INIT_LO,
      ST_INIT_HI,
      ST_SETTLE,
      ST_CHECK,
      ST_DATA,
      ST_CLK_LO,
      ST_CLK_HI,
      ST_BUSY,
      ST_END_CS,
      ST_FINAL
   } ld_state_t;

   localparam logic [2:0] FC_NONE       = 3'd0;
   localparam logic [2:0] FC_INIT_LO_TO = 3'd1;
   localparam logic [2:0] FC_INIT_HI_TO = 3'd2;
   localparam logic [2:0] FC_INIT_ERR   = 3'd3;
   localparam logic [2:0] FC_BUSY_TO    = 3'd4;
   localparam logic [2:0] FC_DONE_TO    = 3'd5;

   function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cfg_ld_sync.sv
module cfg_ld_sync #(
   parameter int unsigned W       = 3,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("cfg_ld_sync: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/cfg_ld_timer.sv
module cfg_ld_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   a_r2_timer_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && zero) |=> zero);

   a_r2_timer_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader
   import cfg_ld_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned PROG_PULSE = 32,
   parameter int unsigned INIT_TO    = 50_000_000,
   parameter int unsigned SETTLE     = 1_000_000,
   parameter int unsigned HALF_CCLK  = 2,
   parameter int unsigned BUSY_TO    = 500_000,
   parameter int unsigned CFG_TO     = 20_000_000,
   parameter bit          CHECK_BUSY = 1'b1,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] s_data,
   input  logic              s_valid,
   input  logic              s_last,
   output logic              s_ready,
   output logic              prog_n,
   output logic              cclk,
   output logic              cs_n,
   output logic              wr_n,
   output logic [DATA_W-1:0] cfg_d,
   input  logic              init_n,
   input  logic              done_in,
   input  logic              busy_in,
   output logic              cfg_ok,
   output logic              cfg_fail,
   output logic [2:0]        fail_code
);

   localparam int unsigned MAX_A  = max_of(PROG_PULSE, INIT_TO);
   localparam int unsigned MAX_B  = max_of(SETTLE, HALF_CCLK);
   localparam int unsigned MAX_C  = max_of(BUSY_TO, CFG_TO);
   localparam int unsigned MAX_T  = max_of(max_of(MAX_A, MAX_B), MAX_C);
   localparam int unsigned TMR_W  = (MAX_T < 2) ? 1 : $clog2(MAX_T);

   if (HALF_CCLK < 2) begin : g_bad_half
      $error("fpga_cfg_loader: HALF_CCLK must be at least 2");
   end
   if (PROG_PULSE < 1 || INIT_TO < 1 || SETTLE < 1 || BUSY_TO < 1 || CFG_TO < 1) begin : g_bad_time
      $error("fpga_cfg_loader: every delay and timeout must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("fpga_cfg_loader: DATA_W must be at least 1");
   end

   // status inputs: bit 0 init_n (idles high), bit 1 done, bit 2 busy
   logic [2:0] stat_raw, stat_s;
   logic       init_s, done_s, busy_s;

   assign stat_raw = {busy_in, done_in, init_n};

   cfg_ld_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b001)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (stat_raw),
      .q     (stat_s)
   );

   assign init_s = stat_s[0];
   assign done_s = stat_s[1];
   assign busy_s = stat_s[2];

   ld_state_t       state_q, state_nx;
   logic            tmr_load, tmr_zero;
   logic [TMR_W-1:0] tmr_val;
   logic            abort;
   logic [2:0]      abort_code;
   logic            success;
   logic            last_q;
   logic            accept;
   ld_state_t       after_edge_st;

   // variant: with busy checking every rising edge is followed by the busy wait
   if (CHECK_BUSY) begin : g_busy_on
      assign after_edge_st = ST_BUSY;
   end else begin : g_busy_off
      assign after_edge_st = ST_CHECK;
   end

   assign accept = (state_q == ST_DATA) && s_valid;

   always_comb begin
      state_nx   = state_q;
      abort      = 1'b0;
      abort_code = FC_NONE;
      success    = 1'b0;
      unique case (state_q)
         ST_IDLE:    if (start) state_nx = ST_PROG;
         ST_PROG:    if (tmr_zero) state_nx = ST_INIT_LO;
         ST_INIT_LO: begin
            if (!init_s) state_nx = ST_INIT_HI;
            else if (tmr_zero) begin
               abort      = 1'b1;
               abort_code = FC_INIT_LO_TO;
            end
         end
         ST_INIT_HI: begin
            if (init_s) state_nx = ST_SETTLE;
            else if (tmr_zero) begin
               abort      = 1'b1;
               abort_code = FC_INIT_HI_TO;
            end
         end
         ST_SETTLE:  if (tmr_zero) state_nx = ST_CHECK;
         ST_CHECK: begin
            if (done_s) state_nx = ST_END_CS;
            else if (!init_s) begin
               abort      = 1'b1;
               abort_code = FC_INIT_ERR;
            end else state_nx = ST_DATA;
         end
         ST_DATA:    if (s_valid) state_nx = ST_CLK_LO;
         ST_CLK_LO:  if (tmr_zero) state_nx = ST_CLK_HI;
         ST_CLK_HI: begin
            if (tmr_zero) begin
               if (after_edge_st == ST_BUSY) state_nx = ST_BUSY;
               else if (last_q)              state_nx = ST_END_CS;
               else                          state_nx = ST_CHECK;
            end
         end
         ST_BUSY: begin
            if (!busy_s) state_nx = last_q ? ST_END_CS : ST_CHECK;
            else if (tmr_zero) begin
               abort      = 1'b1;
               abort_code = FC_BUSY_TO;
            end
         end
         ST_END_CS:  state_nx = ST_FINAL;
         ST_FINAL: begin
            if (done_s && init_s) begin
               success  = 1'b1;
               state_nx = ST_IDLE;
            end else if (tmr_zero) begin
               abort      = 1'b1;
               abort_code = FC_DONE_TO;
            end
         end
         default:    state_nx = ST_IDLE;
      endcase
      if (abort) state_nx = ST_IDLE;
   end

   // each timed state loads its own window on entry
   always_comb begin
      tmr_load = (state_nx != state_q);
      unique case (state_nx)
         ST_PROG:               tmr_val = TMR_W'(PROG_PULSE - 1);
         ST_INIT_LO, ST_INIT_HI: tmr_val = TMR_W'(INIT_TO - 1);
         ST_SETTLE:             tmr_val = TMR_W'(SETTLE - 1);
         ST_CLK_LO, ST_CLK_HI:  tmr_val = TMR_W'(HALF_CCLK - 1);
         ST_BUSY:               tmr_val = TMR_W'(BUSY_TO - 1);
         ST_FINAL:              tmr_val = TMR_W'(CFG_TO - 1);
         default:               tmr_val = '0;
      endcase
   end

   cfg_ld_timer #(
      .W (TMR_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         last_q    <= 1'b0;
         cfg_d     <= '0;
         cfg_ok    <= 1'b0;
         cfg_fail  <= 1'b0;
         fail_code <= FC_NONE;
      end else begin
         state_q  <= state_nx;
         cfg_ok   <= success;
         cfg_fail <= abort;
         if (abort) fail_code <= abort_code;
         if (accept) begin
            cfg_d  <= s_data;
            last_q <= s_last;
         end
      end
   end

   logic selected;
   assign selected = (state_q == ST_SETTLE) || (state_q == ST_CHECK) ||
                     (state_q == ST_DATA)   || (state_q == ST_CLK_LO) ||
                     (state_q == ST_CLK_HI) || (state_q == ST_BUSY);

   assign prog_n  = !((state_q == ST_PROG) || (state_q == ST_INIT_LO));
   assign cs_n    = !selected;
   assign wr_n    = !(selected || (state_q == ST_END_CS));
   assign cclk    = (state_q != ST_CLK_LO);
   assign s_ready = (state_q == ST_DATA);

   // ---------------------------------------------------------------- checks
   a_r5_ready_selected: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |-> (!cs_n && !wr_n && prog_n && cclk));

   a_r2_prog_deselects: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_n |-> (cs_n && wr_n));

   a_r5_data_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cclk) |-> $stable(cfg_d));

   a_r5_cclk_low_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
      !cclk |-> (!cs_n && !wr_n));

   a_r5_cclk_low_min_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cclk) |=> !cclk);

   a_r9_cs_before_wr: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(wr_n) && !cfg_fail) |-> $past(cs_n));

   a_r10_fail_released: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_fail |-> (prog_n && cs_n && wr_n && !s_ready));

   a_r10_fail_code_range: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_fail |-> (fail_code >= 3'd1 && fail_code <= 3'd5));

   a_r10_ok_fail_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_ok && cfg_fail));

   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_ok || cfg_fail) |=> !(cfg_ok || cfg_fail));

endmodule

// File: tb/fpga_cfg_loader_test.sv
`timescale 1ns/1ps
module fpga_cfg_loader_test;

   localparam int P_PROG   = 4;
   localparam int P_INITTO = 20;
   localparam int P_SETTLE = 6;
   localparam int P_HALF   = 2;
   localparam int P_BUSYTO = 10;
   localparam int P_CFGTO  = 30;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] s_data = '0;
   logic       s_valid = 1'b0;
   logic       s_last = 1'b0;
   logic       s_ready;
   logic       prog_n, cclk, cs_n, wr_n;
   logic [7:0] cfg_d;
   logic       init_n = 1'b1;
   logic       done_in = 1'b0;
   logic       busy_in = 1'b0;
   logic       cfg_ok, cfg_fail;
   logic [2:0] fail_code;

   always #2 clk = ~clk;

   fpga_cfg_loader #(
      .DATA_W(8), .PROG_PULSE(P_PROG), .INIT_TO(P_INITTO), .SETTLE(P_SETTLE),
      .HALF_CCLK(P_HALF), .BUSY_TO(P_BUSYTO), .CFG_TO(P_CFGTO), .CHECK_BUSY(1'b1),
      .SYNC_STAGES(2)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .s_data(s_data), .s_valid(s_valid),
      .s_last(s_last), .s_ready(s_ready), .prog_n(prog_n), .cclk(cclk), .cs_n(cs_n),
      .wr_n(wr_n), .cfg_d(cfg_d), .init_n(init_n), .done_in(done_in), .busy_in(busy_in),
      .cfg_ok(cfg_ok), .cfg_fail(cfg_fail), .fail_code(fail_code)
   );

   int tests = 0;
   int fails = 0;

   task automatic check(input bit cond, input string req, input int act, input int exp);
      tests++;
      if (!cond) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // ---------------- target model knobs
   bit m_init_resp = 1'b1;
   bit m_init_rise = 1'b1;
   int m_hi_delay  = 5;
   int m_err_at    = 0;
   int m_done_after = 0;
   int m_busy_len  = 0;

   logic [7:0] sent [16];
   logic [7:0] cap  [16];
   int nbytes = 0;

   initial begin
      bit init_m = 1'b1;
      bit err_hit = 1'b0;
      bit prev_cclk = 1'b1;
      int hi_cnt = 0;
      int busy_cnt = 0;
      forever begin
         @(negedge clk);
         if (!prog_n) begin
            nbytes = 0; err_hit = 1'b0; hi_cnt = 0; busy_cnt = 0;
            if (m_init_resp) init_m = 1'b0;
         end else begin
            if (cclk && !prev_cclk && !cs_n && !wr_n) begin
               if (nbytes < 16) cap[nbytes] = cfg_d;
               nbytes++;
               busy_cnt = m_busy_len;
            end else if (busy_cnt > 0) busy_cnt--;
            if (!init_m && !err_hit && m_init_rise) begin
               hi_cnt++;
               if (hi_cnt >= m_hi_delay) init_m = 1'b1;
            end
            if (m_err_at != 0 && nbytes >= m_err_at && !err_hit) begin
               err_hit = 1'b1;
               init_m  = 1'b0;
            end
         end
         prev_cclk = cclk;
         init_n  = init_m;
         done_in = (m_done_after != 0 && nbytes >= m_done_after);
         busy_in = (busy_cnt > 0);
      end
   end

   // ---------------- observer
   bit ended = 1'b0;
   int ok_cnt = 0, fail_cnt = 0, last_code = 0, rel_ok = 1;
   int cyc = 0;
   int prog_run = 0, prog_min = 1000000, prog_pulses = 0;
   int clk_run = 0, clk_bad = 0;
   int cs_fall = -1, first_ready = -1, cs_rise = -1, wr_rise = -1;
   int accepted = 0;

   task automatic clear_obs();
      ended = 1'b0; ok_cnt = 0; fail_cnt = 0; last_code = 0; rel_ok = 1;
      prog_min = 1000000; prog_pulses = 0; clk_bad = 0;
      cs_fall = -1; first_ready = -1; cs_rise = -1; wr_rise = -1; accepted = 0;
   endtask

   initial begin
      logic pcs = 1'b1, pwr = 1'b1;
      forever begin
         @(negedge clk);
         cyc++;
         if (cfg_ok) begin ok_cnt++; ended = 1'b1; end
         if (cfg_fail) begin
            fail_cnt++; ended = 1'b1; last_code = fail_code;
            if (!(prog_n && cs_n && wr_n)) rel_ok = 0;
         end
         if (!prog_n) prog_run++;
         else if (prog_run > 0) begin
            if (prog_run < prog_min) prog_min = prog_run;
            prog_pulses++; prog_run = 0;
         end
         if (!cclk) clk_run++;
         else if (clk_run > 0) begin
            if (clk_run != P_HALF) clk_bad++;
            clk_run = 0;
         end
         if (pcs && !cs_n) cs_fall = cyc;
         if (!pcs && cs_n) cs_rise = cyc;
         if (!pwr && wr_n) wr_rise = cyc;
         if (s_ready && first_ready < 0) first_ready = cyc;
         if (s_ready && s_valid) accepted++;
         pcs = cs_n; pwr = wr_n;
      end
   end

   // ---------------- stimulus helpers
   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic send_stream(input int n, input logic [7:0] seed);
      for (int i = 0; i < n; i++) begin
         int guard;
         sent[i] = seed ^ 8'(i * 37 + 5);
         s_data  = sent[i];
         s_valid = 1'b1;
         s_last  = (i == n - 1);
         guard = 0;
         while (!s_ready && !ended && guard < 2000) begin
            @(negedge clk); guard++;
         end
         if (ended || guard >= 2000) break;
         @(negedge clk);
      end
      s_valid = 1'b0;
      s_last  = 1'b0;
   endtask

   task automatic wait_end();
      int guard = 0;
      while (!ended && guard < 3000) begin
         @(negedge clk); guard++;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic set_model(input bit resp, input bit rise, input int err_at,
                            input int done_after, input int busy_len);
      m_init_resp = resp; m_init_rise = rise; m_err_at = err_at;
      m_done_after = done_after; m_busy_len = busy_len; m_hi_delay = 5;
   endtask

   // ---------------- scenarios
   task automatic t_reset_state();
      check(prog_n == 1'b1, "R1 reset prog_n", prog_n, 1);
      check(cs_n == 1'b1 && wr_n == 1'b1, "R1 reset cs_n/wr_n", {cs_n, wr_n}, 3);
      check(cclk == 1'b1, "R1 reset cclk", cclk, 1);
      check(s_ready == 1'b0, "R1 reset s_ready", s_ready, 0);
      check(cfg_ok == 1'b0 && cfg_fail == 1'b0, "R1 reset ok/fail", {cfg_ok, cfg_fail}, 0);
   endtask

   task automatic t_normal_load();
      set_model(1, 1, 0, 6, 0);
      clear_obs();
      pulse_start();
      fork
         send_stream(6, 8'hA5);
         begin repeat (40) @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0; end
      join
      wait_end();
      check(ok_cnt == 1 && fail_cnt == 0, "R9 normal load ok pulse", ok_cnt, 1);
      check(nbytes == 6, "R5 normal byte count", nbytes, 6);
      for (int i = 0; i < 6; i++)
         check(cap[i] == sent[i], "R5 byte value", cap[i], sent[i]);
      check(prog_min >= P_PROG, "R2 program pulse width", prog_min, P_PROG);
      check(prog_pulses == 1, "R1 start during run ignored", prog_pulses, 1);
      check(clk_bad == 0, "R5 cclk low width", clk_bad, 0);
      check(first_ready - cs_fall >= P_SETTLE, "R4 settle before first byte",
            first_ready - cs_fall, P_SETTLE);
      check(wr_rise == cs_rise + 1, "R9 cs_n released before wr_n", wr_rise - cs_rise, 1);
   endtask

   task automatic t_busy_wait();
      set_model(1, 1, 0, 5, 3);
      clear_obs();
      pulse_start();
      send_stream(5, 8'h3C);
      wait_end();
      check(ok_cnt == 1 && fail_cnt == 0, "R7 busy held off, load ok", ok_cnt, 1);
      check(nbytes == 5, "R7 busy byte count", nbytes, 5);
      check(cap[4] == sent[4], "R7 last byte after busy", cap[4], sent[4]);
   endtask

   task automatic t_busy_timeout();
      set_model(1, 1, 0, 6, 1000);
      clear_obs();
      pulse_start();
      send_stream(6, 8'h11);
      wait_end();
      check(fail_cnt == 1 && last_code == 4, "R7 busy timeout code", last_code, 4);
      check(nbytes == 1, "R7 no byte after busy timeout", nbytes, 1);
      check(rel_ok == 1, "R10 lines released on busy fail", rel_ok, 1);
   endtask

   task automatic t_init_lo_timeout();
      set_model(0, 1, 0, 6, 0);
      clear_obs();
      pulse_start();
      wait_end();
      check(fail_cnt == 1 && last_code == 1, "R2 init-low timeout code", last_code, 1);
      check(prog_n == 1'b1, "R10 prog released after abort", prog_n, 1);
      check(fail_code == 3'd1, "R10 fail_code held", fail_code, 1);
   endtask

   task automatic t_init_hi_timeout();
      set_model(1, 0, 0, 6, 0);
      clear_obs();
      pulse_start();
      wait_end();
      check(fail_cnt == 1 && last_code == 2, "R3 init-high timeout code", last_code, 2);
      check(cs_fall < 0, "R3 never selected", cs_fall, -1);
   endtask

   task automatic t_init_error();
      set_model(1, 1, 3, 0, 0);
      clear_obs();
      pulse_start();
      send_stream(6, 8'h5A);
      wait_end();
      check(fail_cnt == 1 && last_code == 3, "R6 init error code", last_code, 3);
      check(nbytes == 3, "R6 bytes before error", nbytes, 3);
      check(rel_ok == 1, "R10 lines released on init error", rel_ok, 1);
   endtask

   task automatic t_early_done();
      set_model(1, 1, 0, 4, 0);
      clear_obs();
      pulse_start();
      send_stream(8, 8'hC3);
      wait_end();
      check(ok_cnt == 1 && fail_cnt == 0, "R8 early done ok", ok_cnt, 1);
      check(nbytes == 4, "R8 bytes stop at done", nbytes, 4);
      check(accepted == 4, "R8 no byte accepted after done", accepted, 4);
   endtask

   task automatic t_done_timeout();
      set_model(1, 1, 0, 0, 0);
      clear_obs();
      pulse_start();
      send_stream(4, 8'h77);
      wait_end();
      check(fail_cnt == 1 && last_code == 5, "R9 done timeout code", last_code, 5);
      check(nbytes == 4, "R9 all bytes sent before final wait", nbytes, 4);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      t_reset_state();
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_normal_load();
      t_busy_wait();
      t_busy_timeout();
      t_init_lo_timeout();
      t_init_hi_timeout();
      t_init_error();
      t_early_done();
      t_done_timeout();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule